// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a small processor core and turns them into a single pending indication and a vector index. Requests come from three kinds of source. There are external pins, each with its own edge selection. There are internal peripheral pulses. There is a software break pulse. Each request is latched into a flag register that holds it until the request is taken, until software clears it, or until reset.

Each latched flag is gated by its own enable bit and by a global master enable. A fixed priority encoder then selects the winner among the surviving requests. When the core takes the interrupt by pulsing the acknowledge input, the controller drops the winner's flag and the master enable in one clock edge, so no second interrupt can nest until the core returns or re-enables. Software writes the enable word one byte lane at a time. It can clear any set of flags, and it can enable or disable the master flag.

The flag bits are laid out as follows. Bit 0 is the break request. Bits 1 to NUM_SRC-NUM_EXT-1 are the internal pulse sources. The top NUM_EXT bits are the external pins, with pin k at bit NUM_SRC-NUM_EXT+k. The default is 16 sources and 4 pins, so the pins sit at bits 12 to 15.

Top module: `intc_vectored`

## Requirements
- R1: After reset all flags, all enable bits and the master enable are 0, and pending_o is 0.
- R2: A one-cycle pulse on brk_req_i or soft_req_i[j] sets flag bit 0 or bit j+1 at the next clock edge. The flag holds until it is accepted or cleared through flag_clr_i. When a set and a clear hit the same bit in the same cycle, the set wins.
- R3: Each external pin k has a 2-bit mode field edge_mode_i[2k+1:2k] with 00 = off, 01 = rising, 10 = falling, 11 = both. The selected edge sets flag bit NUM_SRC-NUM_EXT+k no later than 3 clock edges after the pin changes. Edges that the mode does not select leave the flag untouched.
- R4: pending_o is 1 exactly when the master enable is 1 and at least one flag has its enable bit set.
- R5: vec_o is the bit index of the highest-numbered flag whose enable bit is set. A higher index means a higher priority.
- R6: An ack_i pulse while pending_o is 1 clears the flag at index vec_o and clears the master enable at the next edge. An ack_i pulse while pending_o is 0 changes nothing.
- R7: di_i clears the master enable. ei_i or reti_i sets it. When di_i or an accepted ack_i occurs in the same cycle as ei_i or reti_i, the master enable is cleared.
- R8: The break request (bit 0) has the lowest priority and is reported as vector 0. Any other enabled request wins over it.
- R9: en_we_i[b] loads en_wdata_i[8b+7:8b] into enable byte b. Byte lanes whose write strobe is 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | NUM_EXT | Asynchronous external interrupt pins |
| edge_mode_i | input | 2*NUM_EXT | Per-pin edge selection (00 off, 01 rise, 10 fall, 11 both) |
| soft_req_i | input | NUM_SRC-NUM_EXT-1 | Internal peripheral request pulses, flag bits 1 upward |
| brk_req_i | input | 1 | Software break request pulse, flag bit 0 |
| en_we_i | input | NUM_SRC/8 | Byte-lane write strobes for the enable word |
| en_wdata_i | input | NUM_SRC | Enable write data |
| flag_clr_i | input | NUM_SRC | Mask of flags to clear this cycle |
| ei_i | input | 1 | Set master enable |
| di_i | input | 1 | Clear master enable |
| reti_i | input | 1 | Return from interrupt, restores master enable |
| ack_i | input | 1 | Core accepts the pending interrupt |
| pending_o | output | 1 | An enabled request is waiting and the master enable is on |
| vec_o | output | $clog2(NUM_SRC) | Index of the winning request |
| flags_o | output | NUM_SRC | Latched request flags |
| master_en_o | output | 1 | Master enable state |

## Verification
The resolver is exercised with a table of enable and request patterns. Some patterns have a single request. Some stack several requests, which shows that the highest enabled index wins. Others mask the top request, which shows that a disabled higher source yields to an enabled lower one. The remaining patterns enable only bits that carry no request, and these must leave pending_o low. The edge logic is driven by toggling each pin under each mode, which separates selected edges from ignored ones. The acknowledge and return sequences show that the winner's flag and the master enable fall together, while the other flags remain latched and are served in order afterwards.

// File: rtl/intc_pkg.sv
// Package: shared types for the vectored interrupt controller.
// Assumes nothing beyond IEEE 1800-2017.
package intc_pkg;

    // Edge selection for one external pin
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/intc_edge_det.sv
// Module: intc_edge_det
// Synchronizes each external pin through two flops and emits a one-cycle
// event when the edge selected for that pin is seen.
// Assumes: pins are asynchronous. Pins idle low through reset, because a pin
// that is already high when reset is released looks like a rising edge.
module intc_edge_det
    import intc_pkg::*;
#(
    parameter int NUM_EXT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   pin_i,
    input  logic [2*NUM_EXT-1:0] mode_i,
    output logic [NUM_EXT-1:0]   evt_o
);

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        logic [2:0] shr;   // [0],[1] synchronizer, [2] previous settled value
        logic       rise;
        logic       fall;
        edge_mode_e mode;

        // Shift the pin through the synchronizer and history stage
        always_ff @(posedge clk) begin
            if (!rst_n) shr <= '0;
            else        shr <= {shr[1:0], pin_i[g]};
        end

        assign rise = shr[1] & ~shr[2];
        assign fall = ~shr[1] & shr[2];
        assign mode = edge_mode_e'(mode_i[2*g +: 2]);

        // Select the edge event requested by this pin's mode
        always_comb begin
            unique case (mode)
                EDGE_RISE: evt_o[g] = rise;
                EDGE_FALL: evt_o[g] = fall;
                EDGE_BOTH: evt_o[g] = rise | fall;
                default:   evt_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/intc_prio_enc.sv
// Module: intc_prio_enc
// Fixed priority encoder: the highest set index wins.
// Assumes: idx_o is meaningful only when any_o is 1.
module intc_prio_enc #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Scan upward so that the last (highest) hit is kept
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/intc_master_ctl.sv
// Module: intc_master_ctl
// Holds the global interrupt enable. Clearing (disable command or accepted
// interrupt) takes precedence over setting (enable command or return).
module intc_master_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    input  logic reti_i,
    input  logic accept_i,
    output logic master_o
);

    // Update the master enable, clear before set
    always_ff @(posedge clk) begin
        if (!rst_n)                 master_o <= 1'b0;
        else if (di_i || accept_i)  master_o <= 1'b0;
        else if (ei_i || reti_i)    master_o <= 1'b1;
    end

endmodule

// File: rtl/intc_vectored.sv
// Module: intc_vectored (top)
// Latches requests into flags, gates them with per-source enables and the
// master enable, resolves fixed priority, and handles acknowledge.
// Flag layout: bit 0 break, bits 1..NUM_SOFT internal pulses, top NUM_EXT
// bits external pins. Assumes NUM_SRC is a multiple of 8.
module intc_vectored
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_EXT = 4,
    localparam int NUM_SOFT  = NUM_SRC - NUM_EXT - 1,
    localparam int NUM_BYTES = NUM_SRC / 8,
    localparam int VEC_W     = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin_i,
    input  logic [2*NUM_EXT-1:0] edge_mode_i,
    input  logic [NUM_SOFT-1:0]  soft_req_i,
    input  logic                 brk_req_i,
    input  logic [NUM_BYTES-1:0] en_we_i,
    input  logic [NUM_SRC-1:0]   en_wdata_i,
    input  logic [NUM_SRC-1:0]   flag_clr_i,
    input  logic                 ei_i,
    input  logic                 di_i,
    input  logic                 reti_i,
    input  logic                 ack_i,
    output logic                 pending_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic [NUM_SRC-1:0]   flags_o,
    output logic                 master_en_o
);

    logic [NUM_EXT-1:0] ext_evt;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] active;
    logic               any_active;
    logic               accept;

    intc_edge_det #(.NUM_EXT(NUM_EXT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .mode_i (edge_mode_i),
        .evt_o  (ext_evt)
    );

    assign set_mask = {ext_evt, soft_req_i, brk_req_i};
    assign active   = flag_q & en_q;

    intc_prio_enc #(.W(NUM_SRC), .IW(VEC_W)) u_prio (
        .req_i (active),
        .any_o (any_active),
        .idx_o (vec_o)
    );

    assign pending_o = any_active & master_en_o;
    assign accept    = ack_i & pending_o;

    // Clear mask: software clears plus the accepted winner
    always_comb begin
        clr_mask = flag_clr_i;
        if (accept) clr_mask = clr_mask | (NUM_SRC'(1) << vec_o);
    end

    // Request flags: a new request beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | set_mask;
    end

    // Enable word written one byte lane at a time
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_en_lane
        always_ff @(posedge clk) begin
            if (!rst_n)         en_q[8*b +: 8] <= '0;
            else if (en_we_i[b]) en_q[8*b +: 8] <= en_wdata_i[8*b +: 8];
        end
    end

    intc_master_ctl u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei_i     (ei_i),
        .di_i     (di_i),
        .reti_i   (reti_i),
        .accept_i (accept),
        .master_o (master_en_o)
    );

    assign flags_o = flag_q;

endmodule

// File: rtl/intc_vectored_chk.sv
// Module: intc_vectored_chk
// Property checker for intc_vectored, attached by the bind below.
module intc_vectored_chk #(
    parameter int NUM_SRC = 16,
    parameter int NUM_EXT = 4,
    localparam int NUM_SOFT = NUM_SRC - NUM_EXT - 1,
    localparam int VEC_W    = $clog2(NUM_SRC)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SOFT-1:0] soft_req_i,
    input logic                brk_req_i,
    input logic                ei_i,
    input logic                di_i,
    input logic                reti_i,
    input logic                ack_i,
    input logic                pending_o,
    input logic [VEC_W-1:0]    vec_o,
    input logic [NUM_SRC-1:0]  flags_o,
    input logic                master_en_o,
    input logic [NUM_SRC-1:0]  en_q
);

    localparam logic [NUM_SRC-1:0] SOFT_MASK = {{NUM_EXT{1'b0}}, {(NUM_SOFT+1){1'b1}}};

    logic [NUM_SRC-1:0] soft_set;
    logic [NUM_SRC-1:0] act;

    assign soft_set = {{NUM_EXT{1'b0}}, soft_req_i, brk_req_i};
    assign act      = flags_o & en_q;

    assert_pending_needs_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> master_en_o);

    assert_winner_is_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> (act[vec_o] && ((act >> vec_o) == NUM_SRC'(1))));

    assert_ack_drops_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && ack_i) |=> !master_en_o);

    assert_ack_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && ack_i && (int'(vec_o) <= NUM_SOFT) && !soft_set[vec_o])
        |=> !flags_o[$past(vec_o)]);

    assert_di_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !master_en_o);

    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei_i || reti_i) && !di_i && !(ack_i && pending_o)) |=> master_en_o);

    assert_no_spurious_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~$past(flags_o) & SOFT_MASK & ~$past(soft_set)) == '0));

endmodule

bind intc_vectored intc_vectored_chk #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_req_i  (soft_req_i),
    .brk_req_i   (brk_req_i),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .reti_i      (reti_i),
    .ack_i       (ack_i),
    .pending_o   (pending_o),
    .vec_o       (vec_o),
    .flags_o     (flags_o),
    .master_en_o (master_en_o),
    .en_q        (en_q)
);

// File: tb/test_intc_vectored.sv
// Bench for intc_vectored: a vector table for priority resolution, then
// directed tests for reset, edge modes, acknowledge and master control.
module test_intc_vectored;

    localparam int NUM_SRC = 16;
    localparam int NUM_EXT = 4;
    localparam int NUM_SOFT = NUM_SRC - NUM_EXT - 1;
    localparam int EXT0 = NUM_SRC - NUM_EXT;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_EXT-1:0]   ext_pin = '0;
    logic [2*NUM_EXT-1:0] edge_mode = '0;
    logic [NUM_SOFT-1:0]  soft_req = '0;
    logic                 brk_req = 1'b0;
    logic [1:0]           en_we = '0;
    logic [NUM_SRC-1:0]   en_wdata = '0;
    logic [NUM_SRC-1:0]   flag_clr = '0;
    logic                 ei = 1'b0, di = 1'b0, reti = 1'b0, ack = 1'b0;
    logic                 pending;
    logic [3:0]           vec;
    logic [NUM_SRC-1:0]   flags;
    logic                 master;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    intc_vectored #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) i_intc_vectored (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .edge_mode_i(edge_mode),
        .soft_req_i(soft_req), .brk_req_i(brk_req), .en_we_i(en_we),
        .en_wdata_i(en_wdata), .flag_clr_i(flag_clr), .ei_i(ei), .di_i(di),
        .reti_i(reti), .ack_i(ack), .pending_o(pending), .vec_o(vec),
        .flags_o(flags), .master_en_o(master)
    );

    // Table entry: enables, request pattern (bit 0 break, bits 11:1 soft), expectations
    typedef struct packed {
        logic [15:0] en;
        logic [11:0] src;
        logic        pend;
        logic [3:0]  vec;
    } vec_t;

    localparam vec_t TABLE [9] = '{
        '{16'hFFFF, 12'h000, 1'b0, 4'd0},
        '{16'hFFFF, 12'h001, 1'b1, 4'd0},
        '{16'hFFFF, 12'h006, 1'b1, 4'd2},
        '{16'hFFFF, 12'h801, 1'b1, 4'd11},
        '{16'h00FF, 12'h801, 1'b1, 4'd0},
        '{16'h0000, 12'hFFF, 1'b0, 4'd0},
        '{16'h0420, 12'h4A0, 1'b1, 4'd10},
        '{16'h0080, 12'h0A0, 1'b1, 4'd7},
        '{16'hF000, 12'hFFF, 1'b0, 4'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_en(input logic [1:0] we, input logic [15:0] d);
        en_we = we; en_wdata = d; tick(); en_we = '0;
    endtask

    task automatic clr_all();
        flag_clr = '1; tick(); flag_clr = '0;
    endtask

    task automatic pulse_src(input logic [11:0] s);
        brk_req = s[0]; soft_req = s[11:1]; tick(); brk_req = 1'b0; soft_req = '0;
    endtask

    task automatic pulse_ei();  ei = 1'b1;   tick(); ei = 1'b0;   endtask
    task automatic pulse_di();  di = 1'b1;   tick(); di = 1'b0;   endtask
    task automatic pulse_reti(); reti = 1'b1; tick(); reti = 1'b0; endtask
    task automatic pulse_ack(); ack = 1'b1;  tick(); ack = 1'b0;  endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 flags", 32'(flags), 32'h0);
        chk("R1 master", 32'(master), 32'h0);
        chk("R1 pending", 32'(pending), 32'h0);
        // R1: enables reset to zero, so a request with master on is not pending
        pulse_src(12'h002); pulse_ei();
        chk("R1 enables zero", 32'(pending), 32'h0);
        pulse_di(); clr_all();

        // R4 R5 R8: vector table
        foreach (TABLE[i]) begin
            pulse_di(); clr_all();
            set_en(2'b11, TABLE[i].en);
            pulse_src(TABLE[i].src);
            pulse_ei();
            chk("R4 pending", 32'(pending), 32'(TABLE[i].pend));
            if (TABLE[i].pend) chk("R5 vector", 32'(vec), 32'(TABLE[i].vec));
        end

        pulse_di(); clr_all();
        set_en(2'b11, 16'hFFFF);

        // R3: pin 0 rising mode
        edge_mode = 8'b11_00_10_01;      // pin3 both? no: pin3=11 reassigned below
        edge_mode = {2'b00, 2'b11, 2'b10, 2'b01};
        ext_pin[0] = 1'b1; repeat (4) tick();
        chk("R3 rise sets", 32'(flags[EXT0]), 32'h1);
        clr_all();
        ext_pin[0] = 1'b0; repeat (4) tick();
        chk("R3 fall ignored in rise mode", 32'(flags[EXT0]), 32'h0);
        // R3: pin 1 falling mode
        ext_pin[1] = 1'b1; repeat (4) tick();
        chk("R3 rise ignored in fall mode", 32'(flags[EXT0+1]), 32'h0);
        ext_pin[1] = 1'b0; repeat (4) tick();
        chk("R3 fall sets", 32'(flags[EXT0+1]), 32'h1);
        // R3: pin 2 both edges
        ext_pin[2] = 1'b1; repeat (4) tick();
        chk("R3 both rise", 32'(flags[EXT0+2]), 32'h1);
        clr_all();
        ext_pin[2] = 1'b0; repeat (4) tick();
        chk("R3 both fall", 32'(flags[EXT0+2]), 32'h1);
        // R3: pin 3 off
        ext_pin[3] = 1'b1; repeat (4) tick();
        ext_pin[3] = 1'b0; repeat (4) tick();
        chk("R3 off ignored", 32'(flags[EXT0+3]), 32'h0);
        // R5: external pin outranks soft sources
        pulse_src(12'h800); pulse_ei();
        chk("R5 ext over soft", 32'(vec), 32'(EXT0+2));
        pulse_di(); clr_all();

        // R6 R7: acknowledge then return
        pulse_src(12'h208);              // bits 3 and 9
        pulse_ei();
        chk("R5 vec before ack", 32'(vec), 32'd9);
        pulse_ack();
        chk("R6 flags after ack", 32'(flags), 32'h0008);
        chk("R6 master after ack", 32'(master), 32'h0);
        chk("R6 pending after ack", 32'(pending), 32'h0);
        pulse_reti();
        chk("R7 reti restores", 32'(master), 32'h1);
        chk("R7 next vector", 32'(vec), 32'd3);

        // R6: ack without pending is ignored
        pulse_di();
        pulse_ack();
        chk("R6 idle ack flags", 32'(flags), 32'h0008);
        chk("R6 idle ack master", 32'(master), 32'h0);

        // R7: disable beats enable in the same cycle
        ei = 1'b1; di = 1'b1; tick(); ei = 1'b0; di = 1'b0;
        chk("R7 di over ei", 32'(master), 32'h0);
        // R7: accepted ack beats return in the same cycle
        pulse_ei();
        ack = 1'b1; reti = 1'b1; tick(); ack = 1'b0; reti = 1'b0;
        chk("R7 ack over reti", 32'(master), 32'h0);
        chk("R6 ack clears bit3", 32'(flags[3]), 32'h0);

        // R2: set wins over clear, flag holds until cleared
        brk_req = 1'b1; flag_clr = 16'h0001; tick(); brk_req = 1'b0; flag_clr = '0;
        chk("R2 set beats clear", 32'(flags[0]), 32'h1);
        repeat (5) tick();
        chk("R2 flag holds", 32'(flags[0]), 32'h1);
        flag_clr = 16'h0001; tick(); flag_clr = '0;
        chk("R2 software clear", 32'(flags[0]), 32'h0);

        // R8: break lowest, served after the other request
        pulse_src(12'h003); pulse_ei();
        chk("R8 soft over break", 32'(vec), 32'd1);
        pulse_ack(); pulse_reti();
        chk("R8 break vector 0", 32'(vec), 32'd0);
        chk("R8 break pending", 32'(pending), 32'h1);
        pulse_di(); clr_all();

        // R9: byte-lane enable writes
        set_en(2'b11, 16'h0000);
        set_en(2'b01, 16'hFFFF);
        pulse_src(12'h208); pulse_ei();
        chk("R9 low lane only", 32'(vec), 32'd3);
        set_en(2'b10, 16'h0200);
        chk("R9 high lane written", 32'(vec), 32'd9);

        finish_run();
    end

endmodule